// File: doc/BRIEF.md
# Register Attribute Lookup Table

This block keeps a small set of keyed configuration entries. Each entry marks one architectural register as a vector or a scalar. On command, the block expands these sparse entries into two dense lookup tables, one per register bank (integer and floating-point), each with one slot per register number. Software fills the entries through a simple write port and then pulses a rebuild command.

During the rebuild, the block first wipes both tables. It then walks the entries one per clock, in index order, and copies each usable entry into the slot that its key names. Two independent combinational query ports let decode logic ask for the attributes of any register in either bank. While the rebuild runs, the query ports report nothing, and the write port holds off new entry writes.

Top module: `reg_attr_lut`

## Requirements
- R1: After reset, `busy` is 0, `wrReady` is 1 and `bankErr` is 0. Every query returns all-zero attributes.
- R2: An entry write (`wrEn`=1 while `wrReady`=1) stores the valid flag, bank selector, key, vector flag, packed flag and bank field at entry `wrIdx`. The stored entry takes effect at the next rebuild.
- R3: A rebuild pulse accepted while idle raises `busy` on the next clock. `busy` then stays high for exactly 1 + NUM_ENTRIES cycles: one clear cycle plus one cycle per entry.
- R4: Both tables are fully cleared before any entry is applied. A slot that no entry names after the rebuild reads as disabled, even if an earlier rebuild had set it.
- R5: The bank selector 0 targets the integer table and 1 targets the floating-point table. The key is the slot index. An applied entry sets that slot's enabled bit and copies its vector, packed and bank fields.
- R6: Entries are applied in ascending index order. When two entries name the same slot, the higher-numbered entry's fields win.
- R7: An entry whose valid flag is 0 is skipped and changes no slot.
- R8: An entry with a nonzero bank field is skipped and sets `bankErr`. `bankErr` stays set until the next accepted rebuild, which clears it on its first busy cycle.
- R9: While `busy` is high, both query ports return all-zero attributes.
- R10: While `busy` is high, `wrReady` is 0 and an entry write is dropped. The dropped write leaves the stored entry unchanged.
- R11: A rebuild pulse arriving while `busy` is high is ignored. It neither restarts nor extends the walk.
- R12: A query of a disabled slot returns enabled=0, vector=0, packed=0 and bank=0, so the register reads as a scalar.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Entry write strobe |
| wrIdx | input | IDX_W | Entry index to write |
| wrValid | input | 1 | Entry valid flag |
| wrType | input | 1 | Target bank: 0 integer, 1 floating-point |
| wrKey | input | KEY_W | Register number (slot) the entry names |
| wrIsVec | input | 1 | Vector flag for the slot |
| wrPacked | input | 1 | Packed (SIMD) flag for the slot |
| wrBank | input | BANK_W | Bank field; only 0 is usable |
| wrReady | output | 1 | High when entry writes are accepted |
| rebuild | input | 1 | Start clearing and walking the entries |
| busy | output | 1 | Rebuild in progress |
| bankErr | output | 1 | Sticky flag: a walked entry had a reserved bank |
| qaType | input | 1 | Query A bank selector |
| qaReg | input | KEY_W | Query A register number |
| qaEnabled | output | 1 | Query A slot enabled |
| qaIsVec | output | 1 | Query A vector flag |
| qaPacked | output | 1 | Query A packed flag |
| qaBank | output | BANK_W | Query A bank field |
| qbType | input | 1 | Query B bank selector |
| qbReg | input | KEY_W | Query B register number |
| qbEnabled | output | 1 | Query B slot enabled |
| qbIsVec | output | 1 | Query B vector flag |
| qbPacked | output | 1 | Query B packed flag |
| qbBank | output | BANK_W | Query B bank field |

## Verification
The bench builds the block with its default values: 16 entries, 32 slots per bank and a 1-bit bank field. With these values the walk lasts 17 cycles. This leaves room to land a dropped write and an ignored rebuild pulse in the middle of a walk, and the bench checks both.

Query port A sweeps all 64 bank/slot pairs continuously, so every slot of both tables is compared against the model across the runs. The single-bit bank field makes value 1 the reserved case that the error flag must catch.

// File: rtl/rat_pkg.sv
package rat_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_CLEAR = 2'd1,
    ST_WALK  = 2'd2
  } ratState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic clrTables;
    logic applyEn;
    logic clrErr;
  } ratStrobe_t;

  localparam int NUM_BANKS = 2;
  localparam int NUM_QPORTS = 2;
endpackage

// File: rtl/rat_ctrl.sv
module rat_ctrl
  import rat_pkg::*;
#(
  parameter int NUM_ENTRIES = 16,
  localparam int IDX_W = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rebuild,
  output logic             busy,
  output ratStrobe_t       strobe,
  output logic [IDX_W-1:0] applyIdx
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_ENTRIES - 1);

  ratState_t        state;
  logic [IDX_W-1:0] walkCnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      walkCnt <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (rebuild) begin
            state   <= ST_CLEAR;
            walkCnt <= '0;
          end
        end
        ST_CLEAR: state <= ST_WALK;
        ST_WALK: begin
          if (walkCnt == LAST_IDX) begin
            state   <= ST_IDLE;
            walkCnt <= '0;
          end else begin
            walkCnt <= walkCnt + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    busy             = (state != ST_IDLE);
    strobe.clrErr    = (state == ST_IDLE) && rebuild;
    strobe.clrTables = (state == ST_CLEAR);
    strobe.applyEn   = (state == ST_WALK);
    applyIdx         = walkCnt;
  end

  // R3: an accepted rebuild leads to the clear cycle
  assert_clear_follows_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && rebuild) |=> strobe.clrTables);

  // R4: the clear cycle comes right before entry 0 is applied
  assert_walk_after_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.clrTables |=> (strobe.applyEn && applyIdx == '0));

  // R6: busy drops only after the last entry has been walked
  assert_walk_complete_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> ($past(strobe.applyEn) && $past(applyIdx) == LAST_IDX));
endmodule

// File: rtl/rat_datapath.sv
module rat_datapath
  import rat_pkg::*;
#(
  parameter int NUM_ENTRIES = 16,
  parameter int NUM_SLOTS   = 32,
  parameter int BANK_W      = 1,
  localparam int IDX_W = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1,
  localparam int KEY_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
)(
  input  logic                               clk,
  input  logic                               rst_n,
  input  ratStrobe_t                         strobe,
  input  logic [IDX_W-1:0]                   applyIdx,
  input  logic                               busy,
  input  logic                               wrEn,
  input  logic [IDX_W-1:0]                   wrIdx,
  input  logic                               wrValid,
  input  logic                               wrType,
  input  logic [KEY_W-1:0]                   wrKey,
  input  logic                               wrIsVec,
  input  logic                               wrPacked,
  input  logic [BANK_W-1:0]                  wrBank,
  input  logic [NUM_QPORTS-1:0]              qType,
  input  logic [NUM_QPORTS-1:0][KEY_W-1:0]   qReg,
  output logic [NUM_QPORTS-1:0]              qEn,
  output logic [NUM_QPORTS-1:0]              qVec,
  output logic [NUM_QPORTS-1:0]              qPk,
  output logic [NUM_QPORTS-1:0][BANK_W-1:0]  qBank,
  output logic                               bankErr
);
  // entry store
  logic              entValid [NUM_ENTRIES];
  logic              entType  [NUM_ENTRIES];
  logic [KEY_W-1:0]  entKey   [NUM_ENTRIES];
  logic              entVec   [NUM_ENTRIES];
  logic              entPk    [NUM_ENTRIES];
  logic [BANK_W-1:0] entBank  [NUM_ENTRIES];

  // expanded per-bank tables
  logic              tEn   [NUM_BANKS][NUM_SLOTS];
  logic              tVec  [NUM_BANKS][NUM_SLOTS];
  logic              tPk   [NUM_BANKS][NUM_SLOTS];
  logic [BANK_W-1:0] tBank [NUM_BANKS][NUM_SLOTS];

  logic curValid, curType, curVec, curPk;
  logic [KEY_W-1:0]  curKey;
  logic [BANK_W-1:0] curBank;
  logic applyOk, applyBad;

  always_comb begin
    curValid = entValid[applyIdx];
    curType  = entType[applyIdx];
    curKey   = entKey[applyIdx];
    curVec   = entVec[applyIdx];
    curPk    = entPk[applyIdx];
    curBank  = entBank[applyIdx];
    applyOk  = strobe.applyEn && curValid && (curBank == '0);
    applyBad = strobe.applyEn && curValid && (curBank != '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int e = 0; e < NUM_ENTRIES; e++) begin
        entValid[e] <= 1'b0;
        entType[e]  <= 1'b0;
        entKey[e]   <= '0;
        entVec[e]   <= 1'b0;
        entPk[e]    <= 1'b0;
        entBank[e]  <= '0;
      end
    end else if (wrEn && !busy) begin
      entValid[wrIdx] <= wrValid;
      entType[wrIdx]  <= wrType;
      entKey[wrIdx]   <= wrKey;
      entVec[wrIdx]   <= wrIsVec;
      entPk[wrIdx]    <= wrPacked;
      entBank[wrIdx]  <= wrBank;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int b = 0; b < NUM_BANKS; b++) begin
        for (int s = 0; s < NUM_SLOTS; s++) begin
          tEn[b][s]   <= 1'b0;
          tVec[b][s]  <= 1'b0;
          tPk[b][s]   <= 1'b0;
          tBank[b][s] <= '0;
        end
      end
    end else if (strobe.clrTables) begin
      for (int b = 0; b < NUM_BANKS; b++) begin
        for (int s = 0; s < NUM_SLOTS; s++) begin
          tEn[b][s]   <= 1'b0;
          tVec[b][s]  <= 1'b0;
          tPk[b][s]   <= 1'b0;
          tBank[b][s] <= '0;
        end
      end
    end else if (applyOk) begin
      tEn[curType][curKey]   <= 1'b1;
      tVec[curType][curKey]  <= curVec;
      tPk[curType][curKey]   <= curPk;
      tBank[curType][curKey] <= curBank;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             bankErr <= 1'b0;
    else if (strobe.clrErr) bankErr <= 1'b0;
    else if (applyBad)      bankErr <= 1'b1;
  end

  // query ports, one per generate iteration
  for (genvar p = 0; p < NUM_QPORTS; p++) begin : g_qport
    logic hit;
    assign hit      = !busy && tEn[qType[p]][qReg[p]];
    assign qEn[p]   = hit;
    assign qVec[p]  = hit && tVec[qType[p]][qReg[p]];
    assign qPk[p]   = hit && tPk[qType[p]][qReg[p]];
    assign qBank[p] = hit ? tBank[qType[p]][qReg[p]] : '0;
  end

  logic [NUM_BANKS*NUM_SLOTS-1:0] enAll;
  always_comb begin
    for (int b = 0; b < NUM_BANKS; b++)
      for (int s = 0; s < NUM_SLOTS; s++)
        enAll[b*NUM_SLOTS+s] = tEn[b][s];
  end

  // R4: after the clear cycle no slot is enabled
  assert_tables_empty_R4: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.clrTables |=> ($countones(enAll) == 0));

  // R8: the error flag only rises out of an entry walk
  assert_err_from_walk_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bankErr) |-> $past(strobe.applyEn));

  // R10: a new enable appears only when an entry is being applied
  assert_en_only_on_apply_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(enAll) > $countones($past(enAll))) |-> $past(strobe.applyEn));
endmodule

// File: rtl/reg_attr_lut.sv
module reg_attr_lut
  import rat_pkg::*;
#(
  parameter int NUM_ENTRIES = 16,
  parameter int NUM_SLOTS   = 32,
  parameter int BANK_W      = 1,
  localparam int IDX_W = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1,
  localparam int KEY_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wrEn,
  input  logic [IDX_W-1:0]  wrIdx,
  input  logic              wrValid,
  input  logic              wrType,
  input  logic [KEY_W-1:0]  wrKey,
  input  logic              wrIsVec,
  input  logic              wrPacked,
  input  logic [BANK_W-1:0] wrBank,
  output logic              wrReady,
  input  logic              rebuild,
  output logic              busy,
  output logic              bankErr,
  input  logic              qaType,
  input  logic [KEY_W-1:0]  qaReg,
  output logic              qaEnabled,
  output logic              qaIsVec,
  output logic              qaPacked,
  output logic [BANK_W-1:0] qaBank,
  input  logic              qbType,
  input  logic [KEY_W-1:0]  qbReg,
  output logic              qbEnabled,
  output logic              qbIsVec,
  output logic              qbPacked,
  output logic [BANK_W-1:0] qbBank
);
  ratStrobe_t                        strobe;
  logic [IDX_W-1:0]                  applyIdx;
  logic [NUM_QPORTS-1:0]             qType, qEn, qVec, qPk;
  logic [NUM_QPORTS-1:0][KEY_W-1:0]  qReg;
  logic [NUM_QPORTS-1:0][BANK_W-1:0] qBank;

  assign qType = {qbType, qaType};
  assign qReg  = {qbReg, qaReg};

  rat_ctrl #(.NUM_ENTRIES(NUM_ENTRIES)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .rebuild(rebuild),
    .busy(busy), .strobe(strobe), .applyIdx(applyIdx)
  );

  rat_datapath #(.NUM_ENTRIES(NUM_ENTRIES), .NUM_SLOTS(NUM_SLOTS), .BANK_W(BANK_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .applyIdx(applyIdx), .busy(busy),
    .wrEn(wrEn), .wrIdx(wrIdx), .wrValid(wrValid), .wrType(wrType), .wrKey(wrKey),
    .wrIsVec(wrIsVec), .wrPacked(wrPacked), .wrBank(wrBank),
    .qType(qType), .qReg(qReg), .qEn(qEn), .qVec(qVec), .qPk(qPk), .qBank(qBank),
    .bankErr(bankErr)
  );

  assign wrReady   = !busy;
  assign qaEnabled = qEn[0];
  assign qaIsVec   = qVec[0];
  assign qaPacked  = qPk[0];
  assign qaBank    = qBank[0];
  assign qbEnabled = qEn[1];
  assign qbIsVec   = qVec[1];
  assign qbPacked  = qPk[1];
  assign qbBank    = qBank[1];

  // R9: queries stay silent for the whole rebuild
  assert_quiet_while_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (!qaEnabled && !qbEnabled && !qaIsVec && !qbIsVec));

  // R12: a vector or packed report implies an enabled slot
  assert_disabled_scalar_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (qaIsVec || qaPacked) |-> qaEnabled);
endmodule

// File: tb/reg_attr_lut_bench.sv
`timescale 1ns/1ps
module reg_attr_lut_bench;
  localparam int NE = 16;
  localparam int NS = 32;

  logic clk = 0, rst_n = 0;
  logic wrEn = 0, wrValid = 0, wrType = 0, wrIsVec = 0, wrPacked = 0;
  logic [3:0] wrIdx = 0;
  logic [4:0] wrKey = 0;
  logic [0:0] wrBank = 0;
  logic rebuild = 0;
  logic qaType = 0, qbType = 0;
  logic [4:0] qaReg = 0, qbReg = 0;
  logic wrReady, busy, bankErr;
  logic qaEnabled, qaIsVec, qaPacked, qbEnabled, qbIsVec, qbPacked;
  logic [0:0] qaBank, qbBank;

  int total = 0, bad = 0;

  always #2 clk = ~clk;

  reg_attr_lut u_reg_attr_lut (
    .clk(clk), .rst_n(rst_n), .wrEn(wrEn), .wrIdx(wrIdx), .wrValid(wrValid),
    .wrType(wrType), .wrKey(wrKey), .wrIsVec(wrIsVec), .wrPacked(wrPacked),
    .wrBank(wrBank), .wrReady(wrReady), .rebuild(rebuild), .busy(busy),
    .bankErr(bankErr), .qaType(qaType), .qaReg(qaReg), .qaEnabled(qaEnabled),
    .qaIsVec(qaIsVec), .qaPacked(qaPacked), .qaBank(qaBank), .qbType(qbType),
    .qbReg(qbReg), .qbEnabled(qbEnabled), .qbIsVec(qbIsVec), .qbPacked(qbPacked),
    .qbBank(qbBank)
  );

  // behavioural reference model
  int mValid[NE], mType[NE], mKey[NE], mVec[NE], mPk[NE], mBank[NE];
  int tEn[2][NS], tVec[2][NS], tPk[2][NS], tBank[2][NS];
  int mCnt = 0, mErr = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int e = 0; e < NE; e++) begin
        mValid[e] = 0; mType[e] = 0; mKey[e] = 0; mVec[e] = 0; mPk[e] = 0; mBank[e] = 0;
      end
      for (int b = 0; b < 2; b++)
        for (int s = 0; s < NS; s++) begin
          tEn[b][s] = 0; tVec[b][s] = 0; tPk[b][s] = 0; tBank[b][s] = 0;
        end
      mCnt = 0; mErr = 0;
    end else if (mCnt == 0) begin
      if (wrEn) begin
        mValid[wrIdx] = wrValid; mType[wrIdx] = wrType; mKey[wrIdx] = wrKey;
        mVec[wrIdx] = wrIsVec; mPk[wrIdx] = wrPacked; mBank[wrIdx] = wrBank;
      end
      if (rebuild) begin mCnt = NE + 1; mErr = 0; end
    end else if (mCnt == NE + 1) begin
      for (int b = 0; b < 2; b++)
        for (int s = 0; s < NS; s++) begin
          tEn[b][s] = 0; tVec[b][s] = 0; tPk[b][s] = 0; tBank[b][s] = 0;
        end
      mCnt = mCnt - 1;
    end else begin
      automatic int k = NE - mCnt;
      if (mValid[k] != 0) begin
        if (mBank[k] != 0) mErr = 1;
        else begin
          tEn[mType[k]][mKey[k]] = 1; tVec[mType[k]][mKey[k]] = mVec[k];
          tPk[mType[k]][mKey[k]] = mPk[k]; tBank[mType[k]][mKey[k]] = mBank[k];
        end
      end
      mCnt = mCnt - 1;
    end
  end

  function automatic int refQ(input int ty, input int rg);
    if (mCnt != 0 || tEn[ty][rg] == 0) return 0;
    return 8 | (tVec[ty][rg] << 2) | (tPk[ty][rg] << 1) | tBank[ty][rg];
  endfunction

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n) begin
      #0.2;
      check("R3 busy", int'(busy), int'(mCnt != 0));
      check("R10 wrReady", int'(wrReady), int'(mCnt == 0));
      check("R8 bankErr", int'(bankErr), mErr);
      check(mCnt != 0 ? "R9 query A" : "R5 query A",
            {qaEnabled, qaIsVec, qaPacked, qaBank[0]}, refQ(qaType, qaReg));
      check(mCnt != 0 ? "R9 query B" : "R5 query B",
            {qbEnabled, qbIsVec, qbPacked, qbBank[0]}, refQ(qbType, qbReg));
    end
  end

  // query A sweeps every bank/slot pair
  int sweep = 0;
  always @(negedge clk) begin
    {qaType, qaReg} <= 6'(sweep);
    sweep <= sweep + 1;
  end

  task automatic writeEnt(input int idx, input int v, input int ty, input int key,
                          input int vec, input int pk, input int bk);
    @(negedge clk);
    wrEn = 1; wrIdx = 4'(idx); wrValid = 1'(v); wrType = 1'(ty); wrKey = 5'(key);
    wrIsVec = 1'(vec); wrPacked = 1'(pk); wrBank = 1'(bk);
    @(negedge clk);
    wrEn = 0;
  endtask

  task automatic expectB(input string req, input int ty, input int rg, input int exp);
    @(negedge clk);
    qbType = 1'(ty); qbReg = 5'(rg);
    #0.4;
    check(req, {qbEnabled, qbIsVec, qbPacked, qbBank[0]}, exp);
  endtask

  task automatic runRebuild(input bit poke, output int n);
    @(negedge clk); rebuild = 1;
    @(negedge clk); rebuild = 0;
    n = 0;
    forever begin
      #0.4;
      if (!busy) break;
      n++;
      wrEn = 0; rebuild = 0;
      if (n == 1) check("R8 cleared on rebuild", int'(bankErr), 0);
      if (poke && n == 2) begin qbType = 0; qbReg = 5'd9; end
      if (poke && n == 4) begin
        check("R9 query during walk", {qbEnabled, qbIsVec, qbPacked, qbBank[0]}, 0);
        wrEn = 1; wrIdx = 4'd8; wrValid = 1; wrType = 0; wrKey = 5'd20;
        wrIsVec = 1; wrPacked = 0; wrBank = 0;
        check("R10 ready low", int'(wrReady), 0);
      end
      if (poke && n == 6) rebuild = 1;
      @(negedge clk);
    end
    wrEn = 0; rebuild = 0;
  endtask

  initial begin
    #(4 * 20000);
    bad++; total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1;
    #0.4;
    check("R1 busy", int'(busy), 0);
    check("R1 ready", int'(wrReady), 1);
    check("R1 err", int'(bankErr), 0);
    check("R1 query", {qbEnabled, qbIsVec, qbPacked, qbBank[0]}, 0);

    writeEnt(0, 1, 0, 3, 1, 0, 0);
    writeEnt(1, 1, 1, 3, 1, 1, 0);
    writeEnt(2, 1, 0, 7, 1, 0, 0);
    writeEnt(5, 1, 0, 7, 0, 1, 0);
    writeEnt(4, 0, 0, 10, 1, 1, 0);
    writeEnt(6, 1, 1, 12, 1, 0, 1);
    runRebuild(1'b1, n);
    check("R3 busy length", n, NE + 1);
    check("R8 err sticky", int'(bankErr), 1);
    expectB("R5 int slot 3", 0, 3, 8 | 4);
    expectB("R5 fp slot 3", 1, 3, 8 | 4 | 2);
    expectB("R6 later entry wins", 0, 7, 8 | 2);
    expectB("R7 invalid skipped", 0, 10, 0);
    expectB("R8 reserved bank skipped", 1, 12, 0);
    expectB("R10 dropped write", 0, 20, 0);
    expectB("R12 disabled is scalar", 1, 31, 0);

    @(negedge clk);
    check("R11 no restart", int'(busy), 0);

    writeEnt(0, 1, 0, 9, 1, 1, 0);
    writeEnt(6, 1, 1, 12, 0, 1, 0);
    runRebuild(1'b1, n);
    check("R11 busy length unchanged", n, NE + 1);
    check("R8 err stays clear", int'(bankErr), 0);
    expectB("R4 stale slot cleared", 0, 3, 0);
    expectB("R2 rewritten entry", 0, 9, 8 | 4 | 2);
    expectB("R2 fixed bank entry", 1, 12, 8 | 2);

    repeat (70) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule